// File: doc/BRIEF.md
# BAR Window Address Decoder

This block sits beside a device's configuration register file and turns the six programmed base address registers into decoded address windows. Each register holds a type bit and an address field. A set bit 0 selects I/O space, and the address field is then bits [31:2]. A clear bit 0 selects memory space, and the address field is then bits [31:4]. A fixed platform offset for the selected space is added to the address field to form the absolute base of the window. The window then spans that register's aperture size.

Every clock the block compares the incoming bus address against all windows in parallel. It registers the result: a hit flag, the index of the claiming register, and the offset of the address inside that window. It also watches the programmed values. When an address field takes a new nonzero value, it emits a single-cycle change pulse, so that the routing fabric can refresh its view of the device's address ranges.

Top module: `bar_window_decoder`

## Requirements
- R1: `hit`, `hit_idx` and `hit_off` are registered. They reflect the `addr_in` and register values sampled at the previous rising edge. `hit_idx` is always below the number of windows (six by default).
- R2: A register whose address field is all zero claims no address, whatever its aperture size.
- R3: Bit 0 of a register selects the space. With bit 0 set, the address field is the value with bits [1:0] cleared and the base is that field plus `IO_BASE`. With bit 0 clear, the address field is the value with bits [3:0] cleared and the base is that field plus `MEM_BASE`.
- R4: A window claims an address A when base <= A < base + size, computed modulo 2^ADDR_W. A window of size zero claims nothing.
- R5: When several windows claim the same address, the lowest-numbered register wins.
- R6: On a hit, `hit_off` equals the address minus the winning window's base. On a miss, `hit`, `hit_idx` and `hit_off` are all zero.
- R7: `range_chg` is high for exactly one cycle, after the edge at which some register's address field is sampled different from its value at the previous edge and nonzero. It stays low when a field is set to zero or when only type bits change. The window moves to the new base from that same edge.
- R8: While `rst_n` is low at a rising edge, all outputs are cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | Bus address to decode |
| bar_val_flat | input | NUM_BARS*ADDR_W | Programmed register values, register i at bits [i*ADDR_W +: ADDR_W] |
| bar_size_flat | input | NUM_BARS*ADDR_W | Aperture sizes in bytes, same packing |
| hit | output | 1 | Address claimed by a window (registered) |
| hit_idx | output | IDX_W | Index of the winning register |
| hit_off | output | ADDR_W | Address minus winning base, zero on miss |
| range_chg | output | 1 | One-cycle pulse on a nonzero address-field change |

## Verification
The window bound assertion compares the registered offset against the aperture size sampled on the same edge. It therefore assumes that sizes are held steady while addresses are decoded, as the configuration file does. The stimulus changes sizes and register values only on falling edges, with the address held, and never while checking a decode. The change-pulse assertion assumes that register values seen during reset need not raise a pulse. The stimulus keeps all registers zero across the first reset. After the mid-run reset, it does not check the pulse that follows reset release.

// File: rtl/bar_dec_pkg.sv
// Package: shared definitions for the BAR window decoder.
// Assumes register type bit 0 selects the space; low type bit counts per space.
package bar_dec_pkg;
    typedef enum logic {SPACE_MEM = 1'b0, SPACE_IO = 1'b1} space_e;
    localparam int IO_TYPE_BITS  = 2;
    localparam int MEM_TYPE_BITS = 4;
endpackage

// File: rtl/bar_window_cmp.sv
// Module: one window comparator. Strips the type bits from a register value,
// adds the platform offset for its space and checks the address against
// [base, base+size). Purely combinational; assumes size is in bytes.
module bar_window_cmp
    import bar_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0] bar_val,
    input  logic [ADDR_W-1:0] bar_size,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] field,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] IO_MASK  = ADDR_W'((1 << IO_TYPE_BITS) - 1);
    localparam logic [ADDR_W-1:0] MEM_MASK = ADDR_W'((1 << MEM_TYPE_BITS) - 1);

    space_e            space;
    logic [ADDR_W-1:0] base;

    // Decode space, form base and test the address against the window.
    always_comb begin
        space  = space_e'(bar_val[0]);
        field  = bar_val & ~((space == SPACE_IO) ? IO_MASK : MEM_MASK);
        base   = field + ((space == SPACE_IO) ? IO_BASE : MEM_BASE);
        offset = addr - base;
        match  = (field != '0) && (offset < bar_size);
    end
endmodule

// File: rtl/bar_prio_sel.sv
// Module: lowest-index priority selector over the window match vector.
// Assumes NUM >= 1; idx is meaningless when any is low (driven zero).
module bar_prio_sel #(
    parameter int NUM   = 6,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest requesting index is the last written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    logic lower_clear;
    // Independent check that no lower request exists below the chosen index.
    always_comb begin
        lower_clear = 1'b1;
        for (int i = 0; i < NUM; i++) begin
            if (i < int'(idx) && req[i]) lower_clear = 1'b0;
        end
        // R5
        prio_lowest_chk: assert (!any || (req[idx] && lower_clear))
            else $error("priority selector picked a non-lowest request");
    end
endmodule

// File: rtl/bar_change_det.sv
// Module: range-change detector. Keeps the address fields seen at the last
// edge and pulses for one cycle when any field becomes a new nonzero value.
// Assumes fields are already stripped of type bits.
module bar_change_det #(
    parameter int NUM    = 6,
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM*ADDR_W-1:0] field_flat,
    output logic                  range_chg
);
    logic [ADDR_W-1:0] prev [NUM];
    logic              fire;

    // Find any field that moved to a new nonzero value.
    always_comb begin
        fire = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (field_flat[i*ADDR_W +: ADDR_W] != prev[i] &&
                field_flat[i*ADDR_W +: ADDR_W] != '0) fire = 1'b1;
        end
    end

    // Remember the fields and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_chg <= 1'b0;
            for (int i = 0; i < NUM; i++) prev[i] <= '0;
        end else begin
            range_chg <= fire;
            for (int i = 0; i < NUM; i++) prev[i] <= field_flat[i*ADDR_W +: ADDR_W];
        end
    end

    // R7
    stable_no_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(field_flat) == $past(field_flat, 2)) |-> !range_chg)
        else $error("range change pulsed with steady fields");
endmodule

// File: rtl/bar_window_decoder.sv
// Module: top of the BAR window decoder. Runs one comparator per register,
// picks the lowest claiming window and registers hit, index and offset.
// Assumes sizes and register values come from a configuration file and are
// steady around decodes; one cycle from addr_in to outputs.
module bar_window_decoder #(
    parameter int NUM_BARS = 6,
    parameter int ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h4000_0000,
    localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr_in,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_val_flat,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_size_flat,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx,
    output logic [ADDR_W-1:0]          hit_off,
    output logic                       range_chg
);
    logic [NUM_BARS-1:0]          match;
    logic [ADDR_W-1:0]            offs [NUM_BARS];
    logic [NUM_BARS*ADDR_W-1:0]   field_flat;
    logic                         any;
    logic [IDX_W-1:0]             sel;
    logic [ADDR_W-1:0]            size_sel;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
        bar_window_cmp #(
            .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .MEM_BASE(MEM_BASE)
        ) u_cmp (
            .bar_val (bar_val_flat[g*ADDR_W +: ADDR_W]),
            .bar_size(bar_size_flat[g*ADDR_W +: ADDR_W]),
            .addr    (addr_in),
            .field   (field_flat[g*ADDR_W +: ADDR_W]),
            .match   (match[g]),
            .offset  (offs[g])
        );
    end

    bar_prio_sel #(.NUM(NUM_BARS), .IDX_W(IDX_W)) u_prio (
        .req(match), .any(any), .idx(sel)
    );

    bar_change_det #(.NUM(NUM_BARS), .ADDR_W(ADDR_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .field_flat(field_flat), .range_chg(range_chg)
    );

    // Aperture of the selected window, used by the bound check.
    always_comb size_sel = bar_size_flat[int'(sel)*ADDR_W +: ADDR_W];

    // Register the decode result; a miss clears index and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
            hit_off <= '0;
        end else begin
            hit     <= any;
            hit_idx <= any ? sel : '0;
            hit_off <= any ? offs[sel] : '0;
        end
    end

    // R4
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_off < $past(size_sel))
        else $error("offset outside window aperture");

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> int'(hit_idx) < NUM_BARS)
        else $error("hit index out of range");

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_off == '0 && hit_idx == '0))
        else $error("miss left index or offset nonzero");
endmodule

// File: tb/tb_bar_window_decoder.sv
module tb_bar_window_decoder;
    localparam int N = 6;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  addr_in;
    logic [W-1:0]  bv [N];
    logic [W-1:0]  bs [N];
    logic [N*W-1:0] bv_flat, bs_flat;
    logic          hit;
    logic [2:0]    hit_idx;
    logic [W-1:0]  hit_off;
    logic          range_chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            bv_flat[i*W +: W] = bv[i];
            bs_flat[i*W +: W] = bs[i];
        end
    end

    bar_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .bar_val_flat(bv_flat), .bar_size_flat(bs_flat),
        .hit(hit), .hit_idx(hit_idx), .hit_off(hit_off), .range_chg(range_chg)
    );

    // {addr, hit, idx, off}; IO_BASE 0x0100_0000, MEM_BASE 0x4000_0000
    localparam logic [67:0] VEC [16] = '{
        {32'h0100_1000, 1'b1, 3'd1, 32'h0000_0000},
        {32'h0100_10FF, 1'b1, 3'd1, 32'h0000_00FF},
        {32'h0100_1100, 1'b0, 3'd0, 32'h0000_0000},
        {32'h0100_0FFF, 1'b0, 3'd0, 32'h0000_0000},
        {32'h4002_0000, 1'b1, 3'd2, 32'h0000_0000},
        {32'h4002_0FFF, 1'b1, 3'd2, 32'h0000_0FFF},
        {32'h4002_0800, 1'b1, 3'd2, 32'h0000_0800},
        {32'h4002_1000, 1'b1, 3'd3, 32'h0000_0800},
        {32'h4002_17FF, 1'b1, 3'd3, 32'h0000_0FFF},
        {32'h4002_1800, 1'b0, 3'd0, 32'h0000_0000},
        {32'h4000_0010, 1'b0, 3'd0, 32'h0000_0000},
        {32'h0103_0004, 1'b1, 3'd5, 32'h0000_0000},
        {32'h0103_0007, 1'b1, 3'd5, 32'h0000_0003},
        {32'h0103_0008, 1'b0, 3'd0, 32'h0000_0000},
        {32'h0000_1000, 1'b0, 3'd0, 32'h0000_0000},
        {32'h4000_00FF, 1'b0, 3'd0, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic decode(input string tag, input logic [W-1:0] a,
                          input logic eh, input logic [2:0] ei, input logic [W-1:0] eo);
        @(negedge clk);
        addr_in = a;
        @(posedge clk); #1;
        check({tag, " hit"}, W'(hit), W'(eh));
        check({tag, " idx"}, W'(hit_idx), W'(ei));
        check({tag, " off"}, hit_off, eo);
    endtask

    initial begin
        rst_n   = 1'b0;
        addr_in = 32'h0100_1000;
        for (int i = 0; i < N; i++) begin bv[i] = '0; bs[i] = 32'h100; end
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 hit", W'(hit), 0);
        check("R8 idx", W'(hit_idx), 0);
        check("R8 off", hit_off, 0);
        check("R8 chg", W'(range_chg), 0);
        @(negedge clk);
        rst_n = 1'b1;
        bv[0] = 32'h0000_0000; bs[0] = 32'h0000_0100; // disabled (R2)
        bv[1] = 32'h0000_1001; bs[1] = 32'h0000_0100; // I/O, base 0x0100_1000
        bv[2] = 32'h0002_0000; bs[2] = 32'h0000_1000; // mem, base 0x4002_0000
        bv[3] = 32'h0002_0808; bs[3] = 32'h0000_1000; // mem, base 0x4002_0800 (R5 overlap)
        bv[4] = 32'h0000_0010; bs[4] = 32'h0000_0000; // size zero
        bv[5] = 32'h0003_0007; bs[5] = 32'h0000_0004; // I/O, base 0x0103_0004 (R3)
        addr_in = 32'h0000_0000;
        @(posedge clk); #1;
        check("R7 pulse on programming", W'(range_chg), 1);
        @(posedge clk); #1;
        check("R7 pulse single cycle", W'(range_chg), 0);

        for (int v = 0; v < 16; v++)
            decode("R4 vector", VEC[v][67:36], VEC[v][35], VEC[v][34:32], VEC[v][31:0]);

        // R2 zero-address register with nonzero size claims nothing
        decode("R2 disabled window", 32'h4000_0000, 1'b0, 3'd0, 32'h0);
        // R3 platform offset applied per space
        decode("R3 io base", 32'h0103_0005, 1'b1, 3'd5, 32'h1);
        decode("R3 raw address miss", 32'h0003_0004, 1'b0, 3'd0, 32'h0);
        // R5 overlap resolved to lower index
        decode("R5 overlap", 32'h4002_0C00, 1'b1, 3'd2, 32'h0000_0C00);
        // R6 miss clears offset and index after a hit
        decode("R6 pre-hit", 32'h0100_1080, 1'b1, 3'd1, 32'h80);
        decode("R6 miss", 32'h7000_0000, 1'b0, 3'd0, 32'h0);

        // R1 latency: output unchanged before the edge
        @(negedge clk);
        addr_in = 32'h4002_0010;
        #1;
        check("R1 before edge", W'(hit), 0);
        @(posedge clk); #1;
        check("R1 after edge hit", W'(hit), 1);
        check("R1 after edge off", hit_off, 32'h10);

        // R7 move window 1
        @(negedge clk);
        bv[1] = 32'h0000_2001;
        @(posedge clk); #1;
        check("R7 move pulse", W'(range_chg), 1);
        @(posedge clk); #1;
        check("R7 move pulse ends", W'(range_chg), 0);
        decode("R7 new window", 32'h0100_2010, 1'b1, 3'd1, 32'h10);
        decode("R7 old window gone", 32'h0100_1010, 1'b0, 3'd0, 32'h0);
        // R7 type-bit-only change
        @(negedge clk);
        bv[2] = 32'h0002_0008;
        @(posedge clk); #1;
        check("R7 type bits no pulse", W'(range_chg), 0);
        @(posedge clk); #1;
        check("R7 type bits no pulse 2", W'(range_chg), 0);
        // R7 write zero
        @(negedge clk);
        bv[5] = 32'h0000_0001;
        @(posedge clk); #1;
        check("R7 zero write no pulse", W'(range_chg), 0);
        decode("R2 cleared window", 32'h0103_0004, 1'b0, 3'd0, 32'h0);

        // R8 reset mid-run with a hitting address
        decode("R8 pre-reset", 32'h4002_0020, 1'b1, 3'd2, 32'h20);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8 mid reset hit", W'(hit), 0);
        check("R8 mid reset off", hit_off, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule